// File: doc/BRIEF.md
# Serial Result Shifter for a Successive-Approximation Converter

This block is the serial-output side of a 12-bit successive-approximation converter. A falling edge on the active-low chip select starts a conversion. The block drives a trial code towards an external comparator and takes back one decision per bit period, most significant bit first. Each decided bit goes straight onto the serial data output, so the result leaves the block while the conversion is still running rather than after it.

A framing strobe marks the period just before the first data bit. The block also produces an output serial clock, with one high phase per bit period. A mode input chooses whether that clock runs only during the frame or runs all the time.

The serial clock, strobe and data outputs are each given as a value plus an output-enable, so a pad ring can place the tri-state drivers. Chip select gates all three enables. The read input also gates the clock and strobe enables.

Top module: `ser_adc_shifter`

## Requirements
- R1: A conversion starts on the first rising clock edge at which `cs_n` is sampled low after being sampled high on the edge before. `busy_n` is low for exactly 24 cycles beginning with the cycle after that edge, which is 12 bit periods of 2 cycles each.
- R2: `strb_out` is high for exactly the first 2 cycles after the start edge and is low at every other time.
- R3: Each bit period lasts 2 cycles. In the first bit period the trial code is 12'h800. At the end of each of the first 12 bit periods one result bit is decided: `cmp_i` = 1 keeps the trial bit and 0 clears it. `dout` takes the decided bit on that same edge. Result bit 11-j therefore appears on `dout` in cycles 2+2j and 3+2j after the start edge (j = 0..11), most significant bit first, and `dout` changes only on edges where `sclk_out` goes from low to high.
- R4: `dout` is 0 after reset and from cycle 26 after the start edge until the next frame. It is also 0 during the 2 strobe cycles.
- R5: With `free_run` = 0, `sclk_out` is 1 in even cycles 0..24 after the start edge and 0 in all other cycles, including all cycles outside the frame.
- R6: With `free_run` = 1, `sclk_out` alternates every cycle. It is 1 in every even cycle counted from the start edge, both inside and after the frame.
- R7: `dout_oe` equals the inverse of `cs_n` in every cycle.
- R8: `sclk_oe` and `strb_oe` are 1 exactly when `cs_n` = 0 and `rd_n` = 0.
- R9: A conversion in progress cannot be restarted. Raising `cs_n` and dropping it again during a frame leaves the timing and data of R1 to R5 unchanged.
- R10: During and after reset with `cs_n` high, `busy_n` = 1, `strb_out` = 0, `dout` = 0, `sclk_out` = 0 (with `free_run` = 0) and all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select; falling edge starts a conversion |
| rd_n | input | 1 | Active-low read; enables the serial clock and strobe outputs |
| free_run | input | 1 | 1 = serial clock runs continuously, 0 = only during the frame |
| cmp_i | input | 1 | Comparator decision: 1 = input at or above the trial code |
| trial_code | output | 12 | Code presented to the comparator's DAC |
| busy_n | output | 1 | Low while bit decisions are in progress |
| sclk_out | output | 1 | Output serial clock value |
| sclk_oe | output | 1 | Output enable for sclk_out |
| strb_out | output | 1 | Frame strobe value |
| strb_oe | output | 1 | Output enable for strb_out |
| dout | output | 1 | Serial data value, MSB first |
| dout_oe | output | 1 | Output enable for dout |

## Verification
A slot counter that is off by one moves the strobe, the `busy_n` rise and every data bit by two cycles. That shift is visible in the first frame, within 26 cycles of the start edge. A wrong bit-select mask in the successive-approximation register shows up as a corrupted data bit in the period right after the bad decision, so codes with alternating bits, all ones and all zeros are run. A restart that is wrongly accepted shows up as a second strobe within a few cycles of the second falling chip-select edge.

// File: rtl/ser_pkg.sv
package ser_pkg;
    localparam int unsigned DEF_RES_W = 12;

    function automatic int unsigned slot_bits(input int unsigned res_w);
        return $clog2(res_w + 1);
    endfunction
endpackage

// File: rtl/ser_frame_seq.sv
module ser_frame_seq #(
    parameter int unsigned RES_W = ser_pkg::DEF_RES_W,
    localparam int unsigned SW = ser_pkg::slot_bits(RES_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    output logic          start,
    output logic          active,
    output logic [SW-1:0] slot,
    output logic          ph,
    output logic          converting,
    output logic          decide,
    output logic          frame_end,
    output logic          strobe
);
    typedef struct packed {
        logic          active;
        logic [SW-1:0] slot;
        logic          ph;
        logic          cs_prev;
    } seq_t;

    seq_t seq_d, seq_q;

    assign start      = seq_q.cs_prev & ~cs_n & ~seq_q.active;
    assign active     = seq_q.active;
    assign slot       = seq_q.slot;
    assign ph         = seq_q.ph;
    assign converting = seq_q.active && (seq_q.slot < SW'(RES_W));
    assign decide     = converting && seq_q.ph;
    assign frame_end  = seq_q.active && seq_q.ph && (seq_q.slot == SW'(RES_W));
    assign strobe     = seq_q.active && (seq_q.slot == '0);

    always_comb begin
        seq_d         = seq_q;
        seq_d.cs_prev = cs_n;
        seq_d.ph      = ~seq_q.ph;
        if (start) begin
            seq_d.active = 1'b1;
            seq_d.slot   = '0;
            seq_d.ph     = 1'b0;
        end else if (seq_q.active && seq_q.ph) begin
            if (seq_q.slot == SW'(RES_W)) begin
                seq_d.active = 1'b0;
                seq_d.slot   = '0;
            end else begin
                seq_d.slot = seq_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    AST_STRB_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |=> strobe); // R2
    AST_STRB_MAX_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(strobe)) |=> !strobe); // R2
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (converting && $past(converting)) |-> (seq_q.slot >= $past(seq_q.slot))); // R9
endmodule

// File: rtl/ser_sar_core.sv
module ser_sar_core #(
    parameter int unsigned RES_W = ser_pkg::DEF_RES_W,
    localparam int unsigned SW = ser_pkg::slot_bits(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             converting,
    input  logic             decide,
    input  logic [SW-1:0]    slot,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_code
);
    typedef struct packed {
        logic [RES_W-1:0] sar;
    } sar_t;

    sar_t sar_d, sar_q;
    logic [RES_W-1:0] onehot;
    localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

    assign onehot     = converting ? (MSB_ONLY >> slot) : '0;
    assign trial_code = sar_q.sar | onehot;

    always_comb begin
        sar_d = sar_q;
        if (start) begin
            sar_d.sar = '0;
        end else if (decide) begin
            if (cmp_i) sar_d.sar = sar_q.sar | onehot;
            else       sar_d.sar = sar_q.sar & ~onehot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sar_q <= '0;
        else        sar_q <= sar_d;
    end

    AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (trial_code == MSB_ONLY)); // R3
endmodule

// File: rtl/ser_out_drv.sv
module ser_out_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic decide,
    input  logic frame_end,
    input  logic active,
    input  logic ph,
    input  logic cmp_i,
    input  logic free_run,
    input  logic cs_n,
    input  logic rd_n,
    output logic dout,
    output logic dout_oe,
    output logic sclk_out,
    output logic sclk_oe,
    output logic strb_oe
);
    typedef struct packed {
        logic dout;
    } drv_t;

    drv_t drv_d, drv_q;

    assign dout     = drv_q.dout;
    assign dout_oe  = ~cs_n;
    assign sclk_oe  = ~cs_n & ~rd_n;
    assign strb_oe  = ~cs_n & ~rd_n;
    assign sclk_out = ~ph & (free_run | active);

    always_comb begin
        drv_d = drv_q;
        if (decide)         drv_d.dout = cmp_i;
        else if (frame_end) drv_d.dout = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    AST_DOUT_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !drv_q.dout); // R4
    AST_DOUT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drv_q.dout) |-> $past(ph)); // R3
endmodule

// File: rtl/ser_adc_shifter.sv
module ser_adc_shifter #(
    parameter int unsigned RES_W = ser_pkg::DEF_RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             free_run,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_code,
    output logic             busy_n,
    output logic             sclk_out,
    output logic             sclk_oe,
    output logic             strb_out,
    output logic             strb_oe,
    output logic             dout,
    output logic             dout_oe
);
    localparam int unsigned SW = ser_pkg::slot_bits(RES_W);

    logic          start, active, ph, converting, decide, frame_end, strobe;
    logic [SW-1:0] slot;

    ser_frame_seq #(.RES_W(RES_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .start(start), .active(active),
        .slot(slot), .ph(ph), .converting(converting), .decide(decide),
        .frame_end(frame_end), .strobe(strobe)
    );

    ser_sar_core #(.RES_W(RES_W)) sar_i (
        .clk(clk), .rst_n(rst_n), .start(start), .converting(converting),
        .decide(decide), .slot(slot), .cmp_i(cmp_i), .trial_code(trial_code)
    );

    ser_out_drv drv_i (
        .clk(clk), .rst_n(rst_n), .decide(decide), .frame_end(frame_end),
        .active(active), .ph(ph), .cmp_i(cmp_i), .free_run(free_run),
        .cs_n(cs_n), .rd_n(rd_n), .dout(dout), .dout_oe(dout_oe),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .strb_oe(strb_oe)
    );

    assign busy_n   = ~converting;
    assign strb_out = strobe;

    AST_BUSY_WITH_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> strb_out); // R1
endmodule

// File: tb/ser_adc_shifter_tb_top.sv
module ser_adc_shifter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        free_run = 1'b0;
    logic [11:0] model_v = 12'h000;
    logic        cmp_i;
    logic [11:0] trial_code;
    logic        busy_n, sclk_out, sclk_oe, strb_out, strb_oe, dout, dout_oe;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign cmp_i = (model_v >= trial_code);

    ser_adc_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .free_run(free_run),
        .cmp_i(cmp_i), .trial_code(trial_code), .busy_n(busy_n),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .strb_out(strb_out),
        .strb_oe(strb_oe), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input logic [11:0] act, input logic [11:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<50000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic test_reset();
        rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; free_run = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({11'd0, busy_n},   12'd1, "R10 busy_n in reset");
        chk({11'd0, dout},     12'd0, "R10 dout in reset");
        #1 rst_n = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk({11'd0, busy_n},   12'd1, "R10 busy_n after reset");
        chk({11'd0, strb_out}, 12'd0, "R10 strb after reset");
        chk({11'd0, dout},     12'd0, "R4 dout after reset");
        chk({11'd0, sclk_out}, 12'd0, "R10 sclk gated idle");
        chk({11'd0, dout_oe},  12'd0, "R7 dout_oe cs high");
        chk({11'd0, sclk_oe},  12'd0, "R8 sclk_oe cs high");
        chk({11'd0, strb_oe},  12'd0, "R8 strb_oe cs high");
    endtask

    // One conversion frame, checked cycle by cycle from the start edge.
    task automatic run_frame(input logic [11:0] v, input logic fr,
                             input logic rdn, input bit glitch);
        bit cs_low;
        int j;
        @(posedge clk); #1;
        model_v = v; free_run = fr; rd_n = rdn; cs_n = 1'b1;
        repeat (2) @(posedge clk);
        #1 cs_n = 1'b0;
        @(posedge clk);
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            cs_low = !(glitch && (c == 6 || c == 7));
            chk({11'd0, strb_out}, {11'd0, (c < 2)}, $sformatf("R2 strb c=%0d", c));
            chk({11'd0, busy_n}, {11'd0, !(c < 24)}, $sformatf("R1 busy_n c=%0d", c));
            if (c >= 2 && c < 26) begin
                j = (c - 2) / 2;
                chk({11'd0, dout}, {11'd0, v[11 - j]}, $sformatf("R3 dout c=%0d", c));
            end else begin
                chk({11'd0, dout}, 12'd0, $sformatf("R4 dout low c=%0d", c));
            end
            if (fr)
                chk({11'd0, sclk_out}, {11'd0, (c % 2 == 0)}, $sformatf("R6 sclk c=%0d", c));
            else
                chk({11'd0, sclk_out}, {11'd0, (c < 26 && c % 2 == 0)},
                    $sformatf("R5 sclk c=%0d", c));
            chk({11'd0, dout_oe}, {11'd0, cs_low}, $sformatf("R7 dout_oe c=%0d", c));
            chk({11'd0, sclk_oe}, {11'd0, cs_low & !rdn}, $sformatf("R8 sclk_oe c=%0d", c));
            chk({11'd0, strb_oe}, {11'd0, cs_low & !rdn}, $sformatf("R8 strb_oe c=%0d", c));
            @(posedge clk); #1;
            if (glitch && c == 5) cs_n = 1'b1;
            if (glitch && c == 7) cs_n = 1'b0;  // R9 second falling edge mid-frame
        end
        cs_n = 1'b1;
    endtask

    task automatic test_gated_pattern();
        run_frame(12'hA5C, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_free_ones();
        run_frame(12'hFFF, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic test_zero_rd_high();
        run_frame(12'h000, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic test_restart_ignored();
        run_frame(12'h3C9, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic test_back_to_back();
        run_frame(12'h801, 1'b1, 1'b0, 1'b0);
        run_frame(12'h7FE, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        test_reset();
        test_gated_pattern();
        test_free_ones();
        test_zero_rd_high();
        test_restart_ignored();
        test_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule